// File: doc/BRIEF.md
# Bus Master Security Gate

This block sits between a single bus master and the memory system behind it. For every request the master issues, it looks up the target address in an external attribution unit. The unit answers combinationally with two flags: one says the region is exempt from checking, the other says the region is non-secure. The gate combines those flags with the master's configured security level and chooses one of four outcomes. It can forward the request marked Secure, forward it marked Non-secure, swallow it with a harmless OK response, or reject it with an error response.

Rejected requests that end in an error raise a sticky interrupt. A clear input wipes that interrupt, and while the clear input is held it also stops the interrupt from being set. Only one request is in flight at a time. The decision is taken in the cycle the request is accepted. Forwarded requests keep their address, direction, size and write data. The downstream read data and error flag come back to the master as they are.

Top module: `sec_gate_top`

## Requirements
- R1: When the attribution unit flags the address as exempt, the request is forwarded with dn_secure = 1 if cfg_master_ns is 0 and dn_secure = 0 if cfg_master_ns is 1, whatever the non-secure flag says.
- R2: When the address is not exempt and is flagged non-secure, the request is forwarded with dn_secure = 0 for either value of cfg_master_ns.
- R3: When the address is neither exempt nor non-secure and cfg_master_ns is 0, the request is forwarded with dn_secure = 1.
- R4: When the address is neither exempt nor non-secure, cfg_master_ns is 1 and cfg_err_resp is 0, no downstream request is made. The master gets up_rsp_err = 0, and for a read up_rdata = 0.
- R5: In the R4 case with cfg_err_resp = 1, no downstream request is made and the master gets up_rsp_err = 1.
- R6: An R5 rejection sets a sticky interrupt status that drives irq high until cleared. No status is set if irq_clr is high in the accepting cycle.
- R7: irq_clr high drives irq low in the same cycle and clears the status. R4 rejections never raise irq.
- R8: After reset: irq = 0, up_ready = 1, dn_valid = 0, up_rsp_valid = 0.
- R9: A forwarded request carries dn_addr, dn_write, dn_size and dn_wdata equal to the master's values. The size code is 0=1, 1=2, 2=4 or 3=8 bytes, with little-endian lanes. The downstream read data and error come back unchanged, and a downstream error never sets the interrupt.
- R10: Only one request is in flight at a time. up_ready stays low from acceptance until the cycle after up_rsp_valid, and a rejected request answers in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_valid | input | 1 | Master request valid |
| up_ready | output | 1 | Gate can accept a request |
| up_addr | input | ADDR_W | Request address |
| up_write | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | Size code (0..3 = 1,2,4,8 bytes) |
| up_wdata | input | DATA_W | Write data |
| up_rsp_valid | output | 1 | Response pulse to master |
| up_rdata | output | DATA_W | Read data to master |
| up_rsp_err | output | 1 | Error response to master |
| attr_addr | output | ADDR_W | Address presented to attribution unit |
| attr_exempt | input | 1 | Region is exempt from checking |
| attr_ns | input | 1 | Region is non-secure |
| cfg_master_ns | input | 1 | Master is configured non-secure |
| cfg_err_resp | input | 1 | Rejections answer with an error |
| irq_clr | input | 1 | Interrupt clear / suppress |
| irq | output | 1 | Sticky rejection interrupt |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts request |
| dn_addr | output | ADDR_W | Downstream address |
| dn_write | output | 1 | Downstream write flag |
| dn_size | output | 2 | Downstream size code |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_secure | output | 1 | Security attribute (1 = Secure) |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rdata | input | DATA_W | Downstream read data |
| dn_rsp_err | input | 1 | Downstream error |

## Verification
The bench sweeps all four region flag pairs against both master settings, both rejection styles and both directions. It includes the exempt-and-non-secure pair, which catches a design that checks the non-secure flag before the exempt flag: such a design would send a secure-configured master out as Non-secure. Zero data on a swallowed read and the absence of any downstream request catch a gate that leaks blocked traffic. Holding irq_clr through an error rejection, and returning a downstream error on an allowed access, catch an interrupt that ignores suppression or that fires on errors the gate did not cause.

// File: rtl/sec_gate_pkg.sv
package sec_gate_pkg;

  typedef enum logic [1:0] {
    ACT_ABORT,
    ACT_RAZWI,
    ACT_SEC,
    ACT_NONSEC
  } gateAct_e;

  typedef struct packed {
    logic capReq;     // latch the master request
    logic secAttr;    // attribute for the latched request
    logic loadBlock;  // load a locally generated response
    logic blockErr;   // that response is an error
    logic capRsp;     // latch the downstream response
  } gateStrobe_t;

  // Exempt is checked first, then the non-secure flag, then the master setting.
  function automatic gateAct_e decideAct(input logic exempt, input logic nsRegion,
                                         input logic masterNs, input logic errResp);
    if (exempt)        return masterNs ? ACT_NONSEC : ACT_SEC;
    else if (nsRegion) return ACT_NONSEC;
    else if (!masterNs) return ACT_SEC;
    else               return errResp ? ACT_ABORT : ACT_RAZWI;
  endfunction

endpackage

// File: rtl/sec_gate_ctrl.sv
module sec_gate_ctrl
  import sec_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upValid,
  output logic        upReady,
  output logic        upRspValid,
  input  logic        attrExempt,
  input  logic        attrNs,
  input  logic        cfgMasterNs,
  input  logic        cfgErrResp,
  input  logic        irqClr,
  output logic        irq,
  output logic        dnValid,
  input  logic        dnReady,
  input  logic        dnRspValid,
  output gateStrobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_FWD, ST_WAIT, ST_RESP} ctrlState_e;

  ctrlState_e state, stateNext;
  gateAct_e   act;
  logic       accept;
  logic       blocked;
  logic       irqStatus;

  assign act     = decideAct(attrExempt, attrNs, cfgMasterNs, cfgErrResp);
  assign accept  = upValid && (state == ST_IDLE);
  assign blocked = (act == ACT_ABORT) || (act == ACT_RAZWI);

  always_comb begin
    strobe           = '0;
    strobe.capReq    = accept;
    strobe.secAttr   = (act == ACT_SEC);
    strobe.loadBlock = accept && blocked;
    strobe.blockErr  = (act == ACT_ABORT);
    strobe.capRsp    = (state == ST_WAIT) && dnRspValid;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept) stateNext = blocked ? ST_RESP : ST_FWD;
      ST_FWD:  if (dnReady) stateNext = ST_WAIT;
      ST_WAIT: if (dnRspValid) stateNext = ST_RESP;
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              irqStatus <= 1'b0;
    else if (irqClr)                         irqStatus <= 1'b0;
    else if (accept && act == ACT_ABORT)     irqStatus <= 1'b1;
  end

  assign upReady    = (state == ST_IDLE);
  assign dnValid    = (state == ST_FWD);
  assign upRspValid = (state == ST_RESP);
  assign irq        = irqStatus && !irqClr;

  a_r6_abort_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && act == ACT_ABORT && !irqClr) |=> irqStatus);
  a_r6_clear_suppresses: assert property (@(posedge clk) disable iff (!rst_n)
    irqClr |=> !irqStatus);
  a_r7_razwi_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && act == ACT_RAZWI && !irqStatus) |=> !irqStatus);
  a_r4_block_no_dn: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadBlock |=> (!dnValid && upRspValid));
  a_r10_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (dnValid || upRspValid) |-> !upReady);

endmodule

// File: rtl/sec_gate_dp.sv
module sec_gate_dp
  import sec_gate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gateStrobe_t       strobe,
  input  logic [ADDR_W-1:0] upAddr,
  input  logic              upWrite,
  input  logic [SIZE_W-1:0] upSize,
  input  logic [DATA_W-1:0] upWdata,
  input  logic [DATA_W-1:0] dnRdata,
  input  logic              dnRspErr,
  output logic [ADDR_W-1:0] dnAddr,
  output logic              dnWrite,
  output logic [SIZE_W-1:0] dnSize,
  output logic [DATA_W-1:0] dnWdata,
  output logic              dnSecure,
  output logic [DATA_W-1:0] upRdata,
  output logic              upRspErr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dnAddr   <= '0;
      dnWrite  <= 1'b0;
      dnSize   <= '0;
      dnWdata  <= '0;
      dnSecure <= 1'b0;
    end else if (strobe.capReq) begin
      dnAddr   <= upAddr;
      dnWrite  <= upWrite;
      dnSize   <= upSize;
      dnWdata  <= upWdata;
      dnSecure <= strobe.secAttr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upRdata  <= '0;
      upRspErr <= 1'b0;
    end else if (strobe.loadBlock) begin
      upRdata  <= '0;
      upRspErr <= strobe.blockErr;
    end else if (strobe.capRsp) begin
      upRdata  <= dnRdata;
      upRspErr <= dnRspErr;
    end
  end

  a_r4_razwi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadBlock && !strobe.blockErr) |=> (upRdata == '0 && !upRspErr));
  a_r5_abort_err: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadBlock && strobe.blockErr) |=> upRspErr);
  a_r9_rsp_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capRsp |=> (upRdata == $past(dnRdata) && upRspErr == $past(dnRspErr)));

endmodule

// File: rtl/sec_gate_top.sv
module sec_gate_top
  import sec_gate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_write,
  input  logic [1:0]        up_size,
  input  logic [DATA_W-1:0] up_wdata,
  output logic              up_rsp_valid,
  output logic [DATA_W-1:0] up_rdata,
  output logic              up_rsp_err,
  output logic [ADDR_W-1:0] attr_addr,
  input  logic              attr_exempt,
  input  logic              attr_ns,
  input  logic              cfg_master_ns,
  input  logic              cfg_err_resp,
  input  logic              irq_clr,
  output logic              irq,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_write,
  output logic [1:0]        dn_size,
  output logic [DATA_W-1:0] dn_wdata,
  output logic              dn_secure,
  input  logic              dn_rsp_valid,
  input  logic [DATA_W-1:0] dn_rdata,
  input  logic              dn_rsp_err
);

  localparam int SIZE_W = 2;

  gateStrobe_t strobe;

  assign attr_addr = up_addr;

  sec_gate_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .upValid    (up_valid),
    .upReady    (up_ready),
    .upRspValid (up_rsp_valid),
    .attrExempt (attr_exempt),
    .attrNs     (attr_ns),
    .cfgMasterNs(cfg_master_ns),
    .cfgErrResp (cfg_err_resp),
    .irqClr     (irq_clr),
    .irq        (irq),
    .dnValid    (dn_valid),
    .dnReady    (dn_ready),
    .dnRspValid (dn_rsp_valid),
    .strobe     (strobe)
  );

  sec_gate_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .upAddr  (up_addr),
    .upWrite (up_write),
    .upSize  (up_size),
    .upWdata (up_wdata),
    .dnRdata (dn_rdata),
    .dnRspErr(dn_rsp_err),
    .dnAddr  (dn_addr),
    .dnWrite (dn_write),
    .dnSize  (dn_size),
    .dnWdata (dn_wdata),
    .dnSecure(dn_secure),
    .upRdata (up_rdata),
    .upRspErr(up_rsp_err)
  );

  a_r1_exempt_attr: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready && attr_exempt) |=> (dn_valid && dn_secure == !$past(cfg_master_ns)));
  a_r2_ns_region: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready && !attr_exempt && attr_ns) |=> (dn_valid && !dn_secure));
  a_r3_secure_master: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready && !attr_exempt && !attr_ns && !cfg_master_ns) |=> (dn_valid && dn_secure));
  a_r9_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> (dn_addr == $past(up_addr) && dn_size == $past(up_size)));

endmodule

// File: tb/sec_gate_top_bench.sv
module sec_gate_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 64;

  logic clk = 0;
  logic rst_n = 0;
  logic up_valid = 0, up_ready, up_write = 0;
  logic [AW-1:0] up_addr = '0;
  logic [1:0] up_size = '0;
  logic [DW-1:0] up_wdata = '0;
  logic up_rsp_valid, up_rsp_err;
  logic [DW-1:0] up_rdata;
  logic [AW-1:0] attr_addr;
  logic attr_exempt, attr_ns;
  logic cfg_master_ns = 0, cfg_err_resp = 0, irq_clr = 0, irq;
  logic dn_valid, dn_write, dn_secure;
  logic dn_ready = 1;
  logic [AW-1:0] dn_addr;
  logic [1:0] dn_size;
  logic [DW-1:0] dn_wdata;
  logic dn_rsp_valid = 0, dn_rsp_err = 0;
  logic [DW-1:0] dn_rdata = '0;

  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Attribution table: addr[13:12] 0=secure, 1=ns, 2=exempt, 3=exempt+ns
  assign attr_exempt = attr_addr[13];
  assign attr_ns     = attr_addr[12];

  // Downstream model: answers one cycle after handshake
  always @(posedge clk) begin
    dn_rsp_valid <= dn_valid && dn_ready;
    dn_rdata     <= {~dn_addr, dn_addr};
    dn_rsp_err   <= (dn_addr[7:0] == 8'hEE);
  end

  sec_gate_top u_sec_gate_top (.*);

  task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic sawFwd, sawSec, sawWrite;
  logic [AW-1:0] sawAddr;
  logic [1:0] sawSize;
  logic [DW-1:0] sawWdata;

  task automatic runTxn(input logic [AW-1:0] a, input logic wr, input logic [1:0] sz, input logic [DW-1:0] wd);
    int waitCnt = 0;
    sawFwd = 0; sawSec = 0; sawWrite = 0; sawAddr = '0; sawSize = '0; sawWdata = '0;
    @(negedge clk);
    chk(up_ready == 1'b1, "R10 ready before request", {63'd0, up_ready}, 64'd1);
    up_valid = 1; up_addr = a; up_write = wr; up_size = sz; up_wdata = wd;
    @(negedge clk);
    up_valid = 0;
    chk(up_ready == 1'b0, "R10 busy after accept", {63'd0, up_ready}, 64'd0);
    while (!up_rsp_valid && waitCnt < 20) begin
      if (dn_valid) begin
        sawFwd = 1; sawSec = dn_secure; sawWrite = dn_write;
        sawAddr = dn_addr; sawSize = dn_size; sawWdata = dn_wdata;
      end
      @(negedge clk);
      waitCnt++;
    end
    if (waitCnt >= 20) begin
      nChecks++; nFails++;
      $display("FAIL R10 no response actual=0 expected=1");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(irq == 0, "R8 irq", {63'd0, irq}, 0);
    chk(up_ready == 1, "R8 up_ready", {63'd0, up_ready}, 1);
    chk(dn_valid == 0, "R8 dn_valid", {63'd0, dn_valid}, 0);
    chk(up_rsp_valid == 0, "R8 up_rsp_valid", {63'd0, up_rsp_valid}, 0);
    rst_n = 1;

    for (int reg_i = 0; reg_i < 4; reg_i++)
      for (int mns = 0; mns < 2; mns++)
        for (int er = 0; er < 2; er++)
          for (int wr = 0; wr < 2; wr++) begin
            logic ex, nsr, expFwd, expSec, expErr;
            logic [AW-1:0] a;
            logic [DW-1:0] wd;
            logic [1:0] sz;
            ex = reg_i[1]; nsr = reg_i[0];
            if (ex) begin expFwd = 1; expSec = !mns[0]; end
            else if (nsr) begin expFwd = 1; expSec = 0; end
            else if (!mns[0]) begin expFwd = 1; expSec = 1; end
            else begin expFwd = 0; expSec = 0; end
            expErr = !expFwd && er[0];
            a  = 32'h4000_0000 | (reg_i << 12) | ((mns*4 + er*2 + wr) << 3);
            sz = 2'(reg_i + wr);
            wd = {32'hA5A5_0000 | 32'(reg_i), a};
            @(negedge clk);
            cfg_master_ns = mns[0]; cfg_err_resp = er[0];
            irq_clr = 1;
            #1 chk(irq == 0, "R7 clear drops irq", {63'd0, irq}, 0);
            @(negedge clk); irq_clr = 0;
            runTxn(a, wr[0], sz, wd);
            chk(sawFwd == expFwd, expFwd ? "R1 R2 R3 forwarded" : "R4 R5 not forwarded", {63'd0, sawFwd}, {63'd0, expFwd});
            if (expFwd) begin
              chk(sawSec == expSec, ex ? "R1 exempt attribute" : (nsr ? "R2 ns attribute" : "R3 secure attribute"),
                  {63'd0, sawSec}, {63'd0, expSec});
              chk(sawAddr == a && sawSize == sz && sawWrite == wr[0], "R9 request fields",
                  {sawWrite, sawSize, sawAddr}, {wr[0], sz, a});
              if (wr[0]) chk(sawWdata == wd, "R9 write data", sawWdata, wd);
              else chk(up_rdata == {~a, a}, "R9 read data", up_rdata, {~a, a});
              chk(up_rsp_err == 0, "R9 ok response", {63'd0, up_rsp_err}, 0);
            end else begin
              chk(up_rsp_err == expErr, er[0] ? "R5 error response" : "R4 ok response",
                  {63'd0, up_rsp_err}, {63'd0, expErr});
              if (!wr[0]) chk(up_rdata == 0, "R4 zero read", up_rdata, 0);
            end
            @(negedge clk);
            chk(irq == expErr, expErr ? "R6 irq set" : "R7 irq stays low", {63'd0, irq}, {63'd0, expErr});
            chk(up_ready == 1, "R10 ready again", {63'd0, up_ready}, 1);
          end

    // R6 sticky across later allowed traffic, then held clear suppresses
    cfg_master_ns = 1; cfg_err_resp = 1;
    runTxn(32'h4000_0040, 0, 2'd2, '0);
    runTxn(32'h4000_1040, 0, 2'd2, '0);
    @(negedge clk);
    chk(irq == 1, "R6 sticky", {63'd0, irq}, 1);
    irq_clr = 1;
    runTxn(32'h4000_0048, 1, 2'd3, 64'h1234);
    chk(up_rsp_err == 1, "R5 error with clear held", {63'd0, up_rsp_err}, 1);
    @(negedge clk);
    irq_clr = 0;
    #1 chk(irq == 0, "R6 suppressed by held clear", {63'd0, irq}, 0);

    // R9 downstream error passes back without irq
    cfg_master_ns = 0;
    runTxn(32'h4000_00EE, 0, 2'd0, '0);
    chk(up_rsp_err == 1, "R9 downstream error", {63'd0, up_rsp_err}, 1);
    @(negedge clk);
    chk(irq == 0, "R9 downstream error no irq", {63'd0, irq}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule